// File: doc/BRIEF.md
# Double-Buffered Result Store with Read Freeze

This block keeps two equal halves of a byte-wide result memory. One half is published to a host, which reads it through a registered read port. The other half is in progress and belongs to a writer, which stores bytes at offsets of its own choosing. A single-cycle swap request from the writer exchanges the two roles, so the bytes just gathered become host-visible at once and the old published half becomes the new scratch area.

To read a consistent snapshot, the host raises `freeze`, reads the published half and then lowers `freeze`. While frozen, swap requests are thrown away and are not remembered, so a swap may be lost now and then. The `updated` output tells the host that at least one swap has happened since it last released the freeze. Lowering `freeze` clears it.

Each half covers `2**HALF_AW` bytes, which is 1 KB by default. Both ports use half-relative offsets. One select bit picks the physical half and is folded into the top address bit of each port with opposite sense.

Top module: `result_pingpong`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `updated` reads 0.
- R2: A byte written with `wr_en` goes only to the in-progress half. Host reads of the published half return the same data until a swap is accepted.
- R3: A swap request is accepted when `freeze` is 0 in that cycle and was 0 in the cycle before. From the next cycle on, the host reads the bytes the writer stored before the swap.
- R4: A swap request made while `freeze` is 1 is dropped and is not queued. After `freeze` falls, the host still reads the old half until a new request is accepted.
- R5: A swap request made in the cycle in which `freeze` goes from 1 to 0 is dropped.
- R6: `updated` goes to 1 in the cycle after an accepted swap and stays 1 through further accepted swaps.
- R7: `updated` goes to 0 in the cycle after `freeze` goes from 1 to 0. Raising or holding `freeze` leaves it unchanged.
- R8: `rd_data` is registered. It shows the byte at `rd_addr` one clock edge after the address is applied and holds its value between edges.
- R9: A write in the same cycle as an accepted swap lands in the half that becomes published.
- R10: Both ports address `2**HALF_AW` bytes, and every offset of a half can be written and read back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_addr | input | HALF_AW | Writer offset within the in-progress half |
| wr_data | input | DATA_W | Writer byte |
| wr_en | input | 1 | Writer store strobe |
| flip_req | input | 1 | Request to swap the two halves |
| rd_addr | input | HALF_AW | Host offset within the published half |
| rd_data | output | DATA_W | Registered host read data |
| freeze | input | 1 | Host hold; drops swap requests while high |
| updated | output | 1 | New data published since the last freeze release |

## Verification
The assertions assume that `freeze` and `flip_req` are synchronous levels sampled once per clock. They also assume that the level `freeze` holds during reset is the one the first post-reset cycle compares against. The bench drives every input on the falling edge, holds `freeze` low through reset, and keeps each swap request to a single cycle. It sweeps every offset of a 16-byte half in each phase. Expected bytes come from a two-bank model in the bench that moves its own select bit only under the acceptance rule written in R3 to R5.

// File: rtl/rpp_pkg.sv
package rpp_pkg;

  typedef enum logic {BANK_LO = 1'b0, BANK_HI = 1'b1} bank_t;

  // Opposite half of a given bank
  function automatic bank_t other_bank(input bank_t b);
    return (b == BANK_LO) ? BANK_HI : BANK_LO;
  endfunction

  // Swap rule: accepted only with freeze low now and in the previous cycle
  function automatic logic swap_ok(input logic req, input logic frz_now,
                                   input logic frz_prev);
    return req & ~frz_now & ~frz_prev;
  endfunction

endpackage

// File: rtl/rpp_dual_ram.sv
module rpp_dual_ram #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= store[raddr];
  end

endmodule

// File: rtl/rpp_flip_ctrl.sv
module rpp_flip_ctrl
  import rpp_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  flip_req,
  input  logic  freeze,
  output bank_t pub_bank,
  output logic  updated_o,
  output logic  swap_taken,
  output logic  freeze_fall
);
  logic freeze_q;

  // Follows freeze even in reset, so the first post-reset cycle sees a true history
  always_ff @(posedge clk) freeze_q <= freeze;

  assign freeze_fall = freeze_q & ~freeze;
  assign swap_taken  = swap_ok(flip_req, freeze, freeze_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      pub_bank  <= BANK_LO;
      updated_o <= 1'b0;
    end else begin
      if (swap_taken) pub_bank <= other_bank(pub_bank);
      if (freeze_fall)     updated_o <= 1'b0;
      else if (swap_taken) updated_o <= 1'b1;
    end
  end

  assert_swap_applies_R3: assert property (@(posedge clk) disable iff (rst)
    (flip_req && !freeze && !$past(freeze)) |=> (pub_bank != $past(pub_bank)));

  assert_frozen_hold_R4: assert property (@(posedge clk) disable iff (rst)
    freeze |=> $stable(pub_bank));

  assert_release_drop_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(freeze) |=> $stable(pub_bank));

  assert_updated_cause_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(updated_o) |-> (pub_bank != $past(pub_bank)));

  assert_release_clears_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(freeze) |=> !updated_o);

endmodule

// File: rtl/result_pingpong.sv
module result_pingpong
  import rpp_pkg::*;
#(
  parameter int HALF_AW = 10,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [HALF_AW-1:0] wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               wr_en,
  input  logic               flip_req,
  input  logic [HALF_AW-1:0] rd_addr,
  output logic [DATA_W-1:0]  rd_data,
  input  logic               freeze,
  output logic               updated
);
  localparam int PHYS_AW = HALF_AW + 1;

  function automatic logic [PHYS_AW-1:0] phys_addr(input bank_t b,
                                                   input logic [HALF_AW-1:0] off);
    return {logic'(b), off};
  endfunction

  bank_t              pub_bank;
  logic               swap_taken;
  logic               freeze_fall;
  logic [PHYS_AW-1:0] wr_phys;
  logic [PHYS_AW-1:0] rd_phys;

  rpp_flip_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .flip_req   (flip_req),
    .freeze     (freeze),
    .pub_bank   (pub_bank),
    .updated_o  (updated),
    .swap_taken (swap_taken),
    .freeze_fall(freeze_fall)
  );

  assign wr_phys = phys_addr(other_bank(pub_bank), wr_addr);
  assign rd_phys = phys_addr(pub_bank, rd_addr);

  rpp_dual_ram #(.ADDR_W(PHYS_AW), .DATA_W(DATA_W)) u_ram (
    .clk  (clk),
    .we   (wr_en),
    .waddr(wr_phys),
    .wdata(wr_data),
    .raddr(rd_phys),
    .rdata(rd_data)
  );

  assert_ports_apart_R2: assert property (@(posedge clk) disable iff (rst)
    wr_phys[PHYS_AW-1] != rd_phys[PHYS_AW-1]);

  assert_swap_flags_R6: assert property (@(posedge clk) disable iff (rst)
    (swap_taken && !freeze_fall) |=> updated);

endmodule

// File: tb/result_pingpong_tb_top.sv
module result_pingpong_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HAW  = 4;
  localparam int HALF = 1 << HAW;

  logic           clk = 1'b0;
  logic           rst;
  logic [HAW-1:0] wr_addr, rd_addr;
  logic [7:0]     wr_data, rd_data;
  logic           wr_en, flip_req, freeze, updated;

  int tests = 0, fails = 0;
  bit done = 0;

  // Bench model: two banks and a published selector
  logic [7:0] mbank [2][HALF];
  int         mpub = 0;
  bit         mfrz_prev = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  result_pingpong #(.HALF_AW(HAW), .DATA_W(8)) dut_i (
    .clk(clk), .rst(rst), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_en(wr_en), .flip_req(flip_req), .rd_addr(rd_addr),
    .rd_data(rd_data), .freeze(freeze), .updated(updated));

  function automatic logic [7:0] pat(int gen, int i);
    return 8'((gen * 37 + i * 11 + 5) & 255);
  endfunction

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One clock with the given inputs, applied at the falling edge; model advances alike
  task automatic cyc(bit we, int a, int d, bit fl, bit fz);
    wr_en = we; wr_addr = HAW'(a); wr_data = 8'(d); flip_req = fl; freeze = fz;
    @(negedge clk);
    if (we) mbank[1-mpub][a] = 8'(d);
    if (fl && !fz && !mfrz_prev) mpub = 1 - mpub;
    mfrz_prev = fz;
    wr_en = 0; flip_req = 0;
  endtask

  task automatic fill(int gen);
    for (int i = 0; i < HALF; i++) cyc(1, i, pat(gen, i), 0, freeze);
  endtask

  task automatic read_all(string req);
    for (int i = 0; i < HALF; i++) begin
      rd_addr = HAW'(i);
      @(negedge clk);
      mfrz_prev = freeze;
      chk(req, rd_data, mbank[mpub][i]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst = 1; wr_en = 0; flip_req = 0; freeze = 0; wr_addr = 0; wr_data = 0; rd_addr = 0;
    repeat (3) @(negedge clk);
    chk("R1 updated in reset", updated, 0);
    rst = 0;
    @(negedge clk);
    chk("R1 updated after reset", updated, 0);

    // R10 / R3: fill every offset, swap, read every offset
    fill(1);
    cyc(0, 0, 0, 1, 0);
    chk("R6 updated after swap", updated, 1);
    read_all("R3 R10 published gen1");

    // R2: new writes invisible before swap
    fill(2);
    read_all("R2 published unchanged");
    cyc(0, 0, 0, 1, 0);
    chk("R6 updated stays set", updated, 1);
    read_all("R3 published gen2");

    // R8: latency and hold between edges
    rd_addr = 3; @(negedge clk);
    chk("R8 one-edge latency", rd_data, mbank[mpub][3]);
    rd_addr = 9; #1;
    chk("R8 holds before edge", rd_data, mbank[mpub][3]);
    @(negedge clk);
    chk("R8 new address", rd_data, mbank[mpub][9]);

    // R4 / R7: frozen swap dropped
    cyc(0, 0, 0, 0, 1);
    chk("R7 raising freeze keeps updated", updated, 1);
    fill(3);
    cyc(0, 0, 0, 1, 1);
    chk("R7 held freeze keeps updated", updated, 1);
    read_all("R4 frozen view");
    cyc(0, 0, 0, 0, 0);
    chk("R7 release clears updated", updated, 0);
    repeat (3) cyc(0, 0, 0, 0, 0);
    chk("R4 no queued update", updated, 0);
    read_all("R4 not queued");

    // R5: request in the release cycle
    cyc(0, 0, 0, 0, 1);
    cyc(0, 0, 0, 1, 0);
    chk("R5 updated after release swap", updated, 0);
    read_all("R5 release swap dropped");

    // R9: write alongside an accepted swap
    cyc(1, 5, 8'hA5, 1, 0);
    chk("R6 updated after swap", updated, 1);
    read_all("R9 R3 published gen3 plus same-cycle write");
    chk("R9 model sanity", mbank[mpub][5], 8'hA5);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule